// File: doc/BRIEF.md
# Vector Lane Address Generator

This datapath forms one memory address per lane of a wide vector. It takes a 32-bit operation word and two source vectors: a vector of base addresses and a vector of offsets. From the word it decodes the lane width, how each offset is extended and a scale shift. Each result lane is its base element plus the extended offset shifted left by 0 to 3 bit positions (a scale of 1, 2, 4 or 8). The sum wraps at the lane width.

The vector width `VLEN` is a parameter and must be a multiple of 128 bits. The lane array is built from 64-bit slices. A slice works as two independent 32-bit lanes or as one 64-bit lane. In the 64-bit forms a slice can take the whole offset element, or only its low word sign-extended or zero-extended.

A word that does not match the operation pattern raises `illegal` and yields an all-zero result. Every lane is always computed, and the work done never depends on the operand values. With `OUT_REG` set (the default), the result, the flag and the valid are registered, and a result appears one cycle after its input is accepted.

Top module: `vag_top`

## Requirements
- R1: A word is legal only when bits [31:24] = 8'h04, bit 21 = 1 and bits [15:12] = 4'hA. Any other word sets `illegal` = 1 on the corresponding output.
- R2: Form bits [23:22] = 2'b10 selects 32-bit lanes. Lane i (bits [32i+31:32i]) = base lane + (offset lane << shift), mod 2^32. No carry passes between adjacent 32-bit lanes.
- R3: Form bits [23:22] = 2'b11 selects 64-bit lanes that use the full 64-bit offset as unsigned. Lane = base + (offset << shift), mod 2^64.
- R4: Form bits [23:22] = 2'b00 selects 64-bit lanes. Offset bits [31:0] of each lane are sign-extended to 64 bits before scaling, and bits [63:32] have no effect.
- R5: Form bits [23:22] = 2'b01 selects 64-bit lanes. Offset bits [31:0] of each lane are zero-extended to 64 bits before scaling, and bits [63:32] have no effect.
- R6: The shift field, bits [11:10], gives a scale of 1 << field (1, 2, 4 or 8), applied to the extended offset.
- R7: Overflow of a lane sum wraps silently and has no effect on any other lane.
- R8: When `illegal` is 1 on a valid output, `result_vec` is all zeros.
- R9: In reset `out_valid`, `illegal` and `result_vec` are 0. With `OUT_REG` = 1, `out_valid` equals `in_valid` delayed by exactly one clock.
- R10: The register-number fields, bits [20:16], [9:5] and [4:0], have no effect on `result_vec` or `illegal`.
- R11: While `in_valid` is 0, `result_vec` and `illegal` hold their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and word are presented this cycle |
| insn | input | 32 | Operation word |
| base_vec | input | VLEN | Base address vector |
| offs_vec | input | VLEN | Offset vector |
| out_valid | output | 1 | Result is valid |
| illegal | output | 1 | Word did not match the operation pattern |
| result_vec | output | VLEN | Per-lane address vector |

## Verification
Every result, its `illegal` flag and `out_valid` appear on the ports one clock edge after the edge that accepted the input, through a single register stage. The driver applies stimulus on falling edges and queues the expected lanes. A monitor samples on the following falling edge, half a cycle after the result register has updated. It compares `out_valid` every cycle against a one-cycle-delayed copy of `in_valid`. The hold requirement is checked two cycles into an idle gap, after the operands and the word have been changed.

// File: rtl/vag_pkg.sv
package vag_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned SLICE_W = 64;
    localparam int unsigned HALF_W  = SLICE_W / 2;

    localparam logic [7:0] OPC_TOP = 8'h04;
    localparam logic [3:0] OPC_MID = 4'hA;

    // Form selector taken straight from word bits [23:22]
    typedef enum logic [1:0] {
        FORM_SX32 = 2'b00,
        FORM_ZX32 = 2'b01,
        FORM_PK32 = 2'b10,
        FORM_PK64 = 2'b11
    } form_e;

    typedef struct packed {
        logic       legal;
        form_e      form;
        logic [1:0] shamt;
    } dec_t;

    function automatic logic pattern_ok(input logic [7:0] top,
                                        input logic       fixed_one,
                                        input logic [3:0] mid);
        return (top == OPC_TOP) && fixed_one && (mid == OPC_MID);
    endfunction

    // Widen the low half of an offset element according to the form
    function automatic logic [SLICE_W-1:0] widen_offset(input logic [SLICE_W-1:0] v,
                                                       input form_e form);
        logic [SLICE_W-1:0] w;
        unique case (form)
            FORM_SX32: w = {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
            FORM_ZX32: w = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
            default:   w = v;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/vag_decode.sv
module vag_decode
    import vag_pkg::*;
(
    input  logic [WORD_W-1:0] insn,
    output dec_t              dec
);
    logic unused_reg_fields;

    // Register numbers are resolved outside this block
    assign unused_reg_fields = ^{insn[20:16], insn[9:5], insn[4:0]};

    always_comb begin
        dec.legal = pattern_ok(insn[31:24], insn[21], insn[15:12]);
        dec.form  = form_e'(insn[23:22]);
        dec.shamt = insn[11:10];
    end
endmodule

// File: rtl/vag_slice.sv
module vag_slice
    import vag_pkg::*;
(
    input  logic [SLICE_W-1:0] base_i,
    input  logic [SLICE_W-1:0] offs_i,
    input  form_e              form_i,
    input  logic [1:0]         shamt_i,
    output logic [SLICE_W-1:0] sum_o
);
    logic [SLICE_W-1:0] wide_off;
    logic [SLICE_W-1:0] addend;
    logic [HALF_W-1:0]  off_lo_sh;
    logic [HALF_W-1:0]  off_hi_sh;
    logic               split;
    logic [HALF_W:0]    lo_sum;
    logic [HALF_W-1:0]  hi_sum;
    logic               carry_mid;

    always_comb begin
        split     = (form_i == FORM_PK32);
        wide_off  = widen_offset(offs_i, form_i);
        off_lo_sh = offs_i[HALF_W-1:0] << shamt_i;
        off_hi_sh = offs_i[SLICE_W-1:HALF_W] << shamt_i;
        if (split) begin
            addend = {off_hi_sh, off_lo_sh};
        end else begin
            addend = wide_off << shamt_i;
        end
        // One 64-bit adder, cut at the middle for two 32-bit lanes
        lo_sum    = {1'b0, base_i[HALF_W-1:0]} + {1'b0, addend[HALF_W-1:0]};
        carry_mid = lo_sum[HALF_W] & ~split;
        hi_sum    = base_i[SLICE_W-1:HALF_W] + addend[SLICE_W-1:HALF_W]
                  + {{(HALF_W-1){1'b0}}, carry_mid};
        sum_o     = {hi_sum, lo_sum[HALF_W-1:0]};
    end
endmodule

// File: rtl/vag_stage.sv
module vag_stage #(
    parameter int unsigned WIDTH   = 256,
    parameter bit          USE_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic             ill_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             vld_o,
    output logic             ill_o,
    output logic [WIDTH-1:0] data_o
);
    generate
        if (USE_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_o  <= 1'b0;
                    ill_o  <= 1'b0;
                    data_o <= '0;
                end else begin
                    vld_o <= vld_i;
                    if (vld_i) begin
                        ill_o  <= ill_i;
                        data_o <= data_i;
                    end
                end
            end
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign vld_o  = vld_i;
            assign ill_o  = ill_i;
            assign data_o = data_i;
        end
    endgenerate
endmodule

// File: rtl/vag_top.sv
module vag_top
    import vag_pkg::*;
#(
    parameter int unsigned VLEN    = 256,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [VLEN-1:0] base_vec,
    input  logic [VLEN-1:0] offs_vec,
    output logic            out_valid,
    output logic            illegal,
    output logic [VLEN-1:0] result_vec
);
    localparam int unsigned N_SLICE = VLEN / SLICE_W;

    dec_t            dec;
    logic [VLEN-1:0] raw_sum;
    logic [VLEN-1:0] gated_sum;

    vag_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    generate
        for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
            vag_slice u_slice (
                .base_i  (base_vec[s*SLICE_W +: SLICE_W]),
                .offs_i  (offs_vec[s*SLICE_W +: SLICE_W]),
                .form_i  (dec.form),
                .shamt_i (dec.shamt),
                .sum_o   (raw_sum[s*SLICE_W +: SLICE_W])
            );
        end
    endgenerate

    assign gated_sum = dec.legal ? raw_sum : '0;

    vag_stage #(
        .WIDTH   (VLEN),
        .USE_REG (OUT_REG)
    ) u_stage (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_valid),
        .ill_i  (~dec.legal),
        .data_i (gated_sum),
        .vld_o  (out_valid),
        .ill_o  (illegal),
        .data_o (result_vec)
    );
endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
    parameter int unsigned VLEN    = 256,
    parameter bit          OUT_REG = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     insn,
    input logic            out_valid,
    input logic            illegal,
    input logic [VLEN-1:0] result_vec
);
    logic unused_fields;
    assign unused_fields = ^{insn[23:22], insn[20:16], insn[11:0]};

    AST_ILLEGAL_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> (result_vec == '0)); // R8

    generate
        if (OUT_REG) begin : g_seq
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid); // R9
            AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid); // R9
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(result_vec) && $stable(illegal))); // R11
            AST_PATTERN_FLAG: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (illegal == (($past(insn[31:24]) != 8'h04)
                                          || !$past(insn[21])
                                          || ($past(insn[15:12]) != 4'hA)))); // R1
        end
    endgenerate
endmodule

bind vag_top vag_checker #(.VLEN(VLEN), .OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .insn       (insn),
    .out_valid  (out_valid),
    .illegal    (illegal),
    .result_vec (result_vec)
);

// File: tb/sim_vag_top.sv
module sim_vag_top;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   insn = '0;
    logic [VL-1:0] base_vec = '0;
    logic [VL-1:0] offs_vec = '0;
    logic          out_valid;
    logic          illegal;
    logic [VL-1:0] result_vec;

    int checks = 0;
    int errors = 0;

    logic [VL-1:0] exp_res_q[$];
    logic          exp_ill_q[$];
    string         tag_q[$];
    logic          exp_vld = 1'b0;
    logic [VL-1:0] last_res;

    always #2.5ns clk = ~clk;

    vag_top #(.VLEN(VL), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .base_vec(base_vec), .offs_vec(offs_vec),
        .out_valid(out_valid), .illegal(illegal), .result_vec(result_vec)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] form, input logic [1:0] sh,
                                       input logic [4:0] rm, input logic [4:0] rn,
                                       input logic [4:0] rd);
        return {8'h04, form, 1'b1, rm, 4'hA, sh, rn, rd};
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic is_bad(input logic [31:0] w);
        return !(w[31:24] == 8'h04 && w[21] && w[15:12] == 4'hA);
    endfunction

    // Reference: lane arithmetic written with multiplication by the scale
    function automatic logic [VL-1:0] model(input logic [31:0] w,
                                            input logic [VL-1:0] b,
                                            input logic [VL-1:0] o);
        logic [VL-1:0] r;
        logic [63:0]   scale;
        logic [63:0]   ov;
        r     = '0;
        scale = 64'd1 << w[11:10];
        if (is_bad(w)) return r;
        if (w[23:22] == 2'b10) begin
            for (int e = 0; e < VL/32; e++)
                r[e*32 +: 32] = b[e*32 +: 32] + o[e*32 +: 32] * scale[31:0];
        end else begin
            for (int e = 0; e < VL/64; e++) begin
                if (w[23])      ov = o[e*64 +: 64];
                else if (w[22]) ov = {32'h0, o[e*64 +: 32]};
                else            ov = {{32{o[e*64+31]}}, o[e*64 +: 32]};
                r[e*64 +: 64] = b[e*64 +: 64] + ov * scale;
            end
        end
        return r;
    endfunction

    task automatic send(input logic [31:0] w, input logic [VL-1:0] b,
                        input logic [VL-1:0] o, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        insn     = w;
        base_vec = b;
        offs_vec = o;
        exp_res_q.push_back(model(w, b, o));
        exp_ill_q.push_back(is_bad(w));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(posedge clk) exp_vld <= rst ? 1'b0 : in_valid;

    // Monitor: results are due one edge after acceptance, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check(out_valid == exp_vld, "R9", "out_valid latency",
                  VL'(out_valid), VL'(exp_vld));
            if (out_valid) begin
                if (exp_res_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected result", result_vec, '0);
                end else begin
                    automatic logic [VL-1:0] er = exp_res_q.pop_front();
                    automatic logic          ei = exp_ill_q.pop_front();
                    automatic string         tg = tag_q.pop_front();
                    check(illegal == ei, tg, "illegal flag", VL'(illegal), VL'(ei));
                    check(result_vec == er, tg, "result lanes", result_vec, er);
                    last_res = er;
                end
            end
        end
    end

    initial begin
        #1ms;
        errors++;
        $display("FAIL R9 watchdog expired: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [VL-1:0] b, o;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(out_valid == 1'b0 && illegal == 1'b0 && result_vec == '0, "R9",
              "reset state", result_vec, '0);
        rst = 1'b0;
        @(negedge clk);

        // R2 / R3 / R4 / R5 / R6: every form with every shift, random data
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 3; k++) begin
                    send(mk(f[1:0], s[1:0], 5'd1, 5'd2, 5'd3), rnd_vec(), rnd_vec(),
                         f == 2 ? "R2" : f == 3 ? "R3" : f == 0 ? "R4" : "R5");
                end
            end
        end
        // R6 scale by 8 of a small offset in the 64-bit form
        send(mk(2'b11, 2'b11, 5'd0, 5'd0, 5'd0), '0, {(VL/64){64'd5}}, "R6");

        // R4 negative low words, junk in the upper halves
        o = '0;
        for (int e = 0; e < VL/64; e++) o[e*64 +: 64] = {32'hDEAD_BEEF, 32'hFFFF_FFF0 - e};
        b = {(VL/64){64'h0000_0001_0000_0000}};
        for (int s = 0; s < 4; s++) send(mk(2'b00, s[1:0], 5'd4, 5'd5, 5'd6), b, o, "R4");
        // R5 same patterns zero-extended
        for (int s = 0; s < 4; s++) send(mk(2'b01, s[1:0], 5'd4, 5'd5, 5'd6), b, o, "R5");

        // R2 / R7 carry must not cross the 32-bit lane boundary
        send(mk(2'b10, 2'b00, 5'd0, 5'd0, 5'd0), {(VL/32){32'hFFFF_FFFF}},
             {(VL/32){32'h0000_0001}}, "R2");
        // R7 wrap in 64-bit lanes
        send(mk(2'b11, 2'b11, 5'd0, 5'd0, 5'd0), {(VL/64){64'hFFFF_FFFF_FFFF_FFF8}},
             {(VL/64){64'h2000_0000_0000_0003}}, "R7");
        send(mk(2'b00, 2'b10, 5'd0, 5'd0, 5'd0), '0, {(VL/64){64'h0000_0000_8000_0000}}, "R7");

        // R10 register fields do not matter
        b = rnd_vec();
        o = rnd_vec();
        for (int k = 0; k < 4; k++)
            send(mk(2'b11, 2'b01, 5'($urandom), 5'($urandom), 5'($urandom)), b, o, "R10");

        // R1 / R8 malformed words
        b = rnd_vec();
        o = rnd_vec();
        send(mk(2'b11, 2'b00, 5'd1, 5'd1, 5'd1) & ~32'h0020_0000, b, o, "R1");
        send(mk(2'b10, 2'b01, 5'd1, 5'd1, 5'd1) ^ 32'h0100_0000, b, o, "R8");
        send(mk(2'b01, 2'b10, 5'd1, 5'd1, 5'd1) ^ 32'h0000_1000, b, o, "R8");
        send(mk(2'b00, 2'b11, 5'd1, 5'd1, 5'd1) ^ 32'h8000_0000, b, o, "R1");
        send(mk(2'b11, 2'b10, 5'd2, 5'd3, 5'd4), b, o, "R1");

        // R11 hold while idle with disturbed inputs
        idle();
        insn     = 32'hFFFF_FFFF;
        base_vec = rnd_vec();
        offs_vec = rnd_vec();
        @(negedge clk);
        @(negedge clk);
        check(result_vec == last_res && illegal == 1'b0, "R11", "hold while idle",
              result_vec, last_res);

        repeat (3) @(negedge clk);
        check(exp_res_q.size() == 0, "R9", "results outstanding",
              VL'(exp_res_q.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule